// File: doc/BRIEF.md
# Serial Display Register Writer

This block is a transmit-only serial master that loads 16-bit values into the indexed registers of a display controller. Every register write goes out as two separate 24-bit frames. The first frame names the register index. The second frame carries the value. Chip select is framed around each frame on its own, and the link clock is a divided copy of the system clock.

A host starts a single write with a one-cycle request that carries a register number and a value. It then waits on `busy` and `done`. A second request input starts a built-in power-up sequence. That sequence takes the panel out of shutdown and then programs the output-control register. The output-control word is composed from four option inputs for scan direction, colour order and display reversal.

Top module: `spi_panel_writer`

## Requirements
- R1: After reset, and whenever no operation is running, `spi_sck` is 1, `spi_cs_n` is 1, `busy` is 0 and `done` is 0.
- R2: Every frame is 24 bits long and is sent MSB first. `spi_mosi` changes only while `spi_sck` is low. The receiver takes each bit on the rising edge of `spi_sck` (clock idles high).
- R3: The index frame is the byte 0x74, then 0x00, then the 8-bit register number.
- R4: The data frame follows the index frame. It is the byte 0x76, then the value's bits 15:8, then its bits 7:0.
- R5: `spi_cs_n` goes low for each frame on its own. Between two frames it stays high for at least CLK_DIV system clock cycles.
- R6: Within a frame, consecutive rising edges of `spi_sck` are exactly CLK_DIV system clock cycles apart.
- R7: `busy` is 1 from the cycle after an accepted request until the operation ends. `done` is then 1 for exactly one cycle, and `busy` is already 0 in that cycle.
- R8: A `wr_start` or `init_start` that arrives while `busy` is 1 is ignored. No extra frame is sent and the running write's content is unchanged.
- R9: `init_start` sends four frames in this order: a write of 0x0000 to register 0x11, then a write of the output-control word to register 0x01. `done` pulses once, at the end of the sequence.
- R10: The output-control word is 0x00EF ORed with these option bits: `init_opts[0]` sets bit 8 (left-to-right scan), `init_opts[1]` sets bit 9 (top-to-bottom scan), `init_opts[2]` sets bit 11 (BGR order) and `init_opts[3]` sets bit 13 (normal display).
- R11: When `init_start` and `wr_start` are both 1 in the same idle cycle, the power-up sequence runs and the single write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | One-cycle request for a single register write |
| wr_reg | input | 8 | Register number for the write |
| wr_value | input | 16 | Value for the write |
| init_start | input | 1 | One-cycle request for the power-up sequence |
| init_opts | input | 4 | Option bits: [0] left-to-right, [1] top-to-bottom, [2] BGR, [3] normal display |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when an operation ends |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Two events can fall in the same cycle. The first is a request for a single write and a request for the power-up sequence, both arriving while the block is idle. The second is a new request arriving while a write is in flight. The bench raises both request lines on one edge and checks the result on the wire: exactly four frames must appear, with the shutdown and output-control content, and none may carry the competing write's register or value. The bench also pulses a request in the middle of a write. It then counts frames and compares the running write's frames to the original request.

// File: rtl/spi_pw_pkg.sv
package spi_pw_pkg;
  localparam int REG_W   = 8;
  localparam int VAL_W   = 16;
  localparam int PFX_W   = 8;
  localparam int FRAME_W = PFX_W + VAL_W;

  localparam logic [PFX_W-1:0] IDX_PREFIX = 8'h74;
  localparam logic [PFX_W-1:0] DAT_PREFIX = 8'h76;

  localparam logic [REG_W-1:0] REG_SHUTDOWN = 8'h11;
  localparam logic [REG_W-1:0] REG_OUTCTL   = 8'h01;
  localparam logic [VAL_W-1:0] VAL_WAKE     = 16'h0000;

  localparam logic [VAL_W-1:0] OUTCTL_BASE = 16'h2AEF;
  localparam int BIT_LR   = 8;
  localparam int BIT_TB   = 9;
  localparam int BIT_BGR  = 11;
  localparam int BIT_NORM = 13;
  localparam logic [VAL_W-1:0] OUTCTL_MASK =
    (16'h1 << BIT_LR) | (16'h1 << BIT_TB) | (16'h1 << BIT_BGR) | (16'h1 << BIT_NORM);

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_IDX, SQ_IDX_W, SQ_DAT, SQ_DAT_W
  } seq_state_t;

  typedef enum logic [2:0] {
    SH_IDLE, SH_LEAD, SH_LOW, SH_HIGH, SH_GAP
  } sh_state_t;

  function automatic logic [FRAME_W-1:0] index_frame(input logic [REG_W-1:0] r);
    index_frame = {IDX_PREFIX, {(VAL_W-REG_W){1'b0}}, r};
  endfunction

  function automatic logic [FRAME_W-1:0] data_frame(input logic [VAL_W-1:0] v);
    data_frame = {DAT_PREFIX, v};
  endfunction

  function automatic logic [VAL_W-1:0] outctl_word(input logic [3:0] opts);
    logic [VAL_W-1:0] w;
    w = OUTCTL_BASE & ~OUTCTL_MASK;
    w[BIT_LR]   = opts[0];
    w[BIT_TB]   = opts[1];
    w[BIT_BGR]  = opts[2];
    w[BIT_NORM] = opts[3];
    outctl_word = w;
  endfunction
endpackage

// File: rtl/spi_pw_shifter.sv
module spi_pw_shifter
  import spi_pw_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int W       = FRAME_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] frame,
  output logic         frame_done,
  output logic         sck,
  output logic         mosi,
  output logic         cs_n
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = $clog2(CLK_DIV + 1);
  localparam int BIT_W = $clog2(W + 1);

  sh_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bits;
  logic [W-1:0]     sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SH_IDLE;
      cnt        <= '0;
      bits       <= '0;
      sr         <= '0;
      sck        <= 1'b1;
      mosi       <= 1'b0;
      cs_n       <= 1'b1;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (st)
        SH_IDLE: begin
          if (load) begin
            sr   <= frame;
            mosi <= frame[W-1];
            cs_n <= 1'b0;
            bits <= '0;
            cnt  <= CNT_W'(HALF - 1);
            st   <= SH_LEAD;
          end
        end
        SH_LEAD: begin
          if (cnt == '0) begin
            sck <= 1'b0;
            cnt <= CNT_W'(HALF - 1);
            st  <= SH_LOW;
          end else cnt <= cnt - 1'b1;
        end
        SH_LOW: begin
          if (cnt == '0) begin
            sck <= 1'b1;
            cnt <= CNT_W'(HALF - 1);
            st  <= SH_HIGH;
          end else cnt <= cnt - 1'b1;
        end
        SH_HIGH: begin
          if (cnt == '0) begin
            if (bits == BIT_W'(W - 1)) begin
              cs_n <= 1'b1;
              cnt  <= CNT_W'(CLK_DIV - 1);
              st   <= SH_GAP;
            end else begin
              bits <= bits + 1'b1;
              sr   <= sr << 1;
              mosi <= sr[W-2];
              sck  <= 1'b0;
              cnt  <= CNT_W'(HALF - 1);
              st   <= SH_LOW;
            end
          end else cnt <= cnt - 1'b1;
        end
        SH_GAP: begin
          if (cnt == '0) begin
            frame_done <= 1'b1;
            st         <= SH_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  // Checker state: rising edges per frame and high time of chip select
  logic [BIT_W-1:0] rise_cnt;
  logic [CNT_W-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_cnt <= '0;
      hi_cnt   <= CNT_W'(CLK_DIV);
    end else begin
      if (st == SH_IDLE) rise_cnt <= '0;
      else if (st == SH_LOW && cnt == '0) rise_cnt <= rise_cnt + 1'b1;
      if (!cs_n) hi_cnt <= '0;
      else if (hi_cnt < CNT_W'(CLK_DIV)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R1
  sck_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sck);
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n) && sck && $past(sck)) |-> $stable(mosi));
  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (rise_cnt == BIT_W'(W)));
  // R5
  cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (hi_cnt >= CNT_W'(CLK_DIV)));
endmodule

// File: rtl/spi_pw_seq.sv
module spi_pw_seq
  import spi_pw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_start,
  input  logic [REG_W-1:0]   wr_reg,
  input  logic [VAL_W-1:0]   wr_value,
  input  logic               init_start,
  input  logic [3:0]         init_opts,
  input  logic               sh_done,
  output logic               sh_load,
  output logic [FRAME_W-1:0] sh_frame,
  output logic               busy,
  output logic               done
);
  seq_state_t       st;
  logic [REG_W-1:0] cur_reg;
  logic [VAL_W-1:0] cur_val;
  logic [VAL_W-1:0] ctl_word;
  logic             in_init;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      cur_reg  <= '0;
      cur_val  <= '0;
      ctl_word <= '0;
      in_init  <= 1'b0;
      sh_load  <= 1'b0;
      sh_frame <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      sh_load <= 1'b0;
      done    <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (init_start) begin
            in_init  <= 1'b1;
            cur_reg  <= REG_SHUTDOWN;
            cur_val  <= VAL_WAKE;
            ctl_word <= outctl_word(init_opts);
            busy     <= 1'b1;
            st       <= SQ_IDX;
          end else if (wr_start) begin
            in_init <= 1'b0;
            cur_reg <= wr_reg;
            cur_val <= wr_value;
            busy    <= 1'b1;
            st      <= SQ_IDX;
          end
        end
        SQ_IDX: begin
          sh_load  <= 1'b1;
          sh_frame <= index_frame(cur_reg);
          st       <= SQ_IDX_W;
        end
        SQ_IDX_W: if (sh_done) st <= SQ_DAT;
        SQ_DAT: begin
          sh_load  <= 1'b1;
          sh_frame <= data_frame(cur_val);
          st       <= SQ_DAT_W;
        end
        SQ_DAT_W: begin
          if (sh_done) begin
            if (in_init && cur_reg == REG_SHUTDOWN) begin
              cur_reg <= REG_OUTCTL;
              cur_val <= ctl_word;
              st      <= SQ_IDX;
            end else begin
              in_init <= 1'b0;
              busy    <= 1'b0;
              done    <= 1'b1;
              st      <= SQ_IDLE;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R7
  busy_ends_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  ignore_busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !in_init && (wr_start || init_start)) |=> ($stable(cur_reg) && $stable(cur_val)));
  // R11
  init_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && init_start && wr_start) |=> (in_init && cur_reg == REG_SHUTDOWN));
endmodule

// File: rtl/spi_panel_writer.sv
module spi_panel_writer
  import spi_pw_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_start,
  input  logic [7:0]  wr_reg,
  input  logic [15:0] wr_value,
  input  logic        init_start,
  input  logic [3:0]  init_opts,
  output logic        busy,
  output logic        done,
  output logic        spi_sck,
  output logic        spi_mosi,
  output logic        spi_cs_n
);
  logic               sh_load;
  logic               sh_done;
  logic [FRAME_W-1:0] sh_frame;

  spi_pw_seq u_seq (
    .clk(clk), .rst(rst),
    .wr_start(wr_start), .wr_reg(wr_reg), .wr_value(wr_value),
    .init_start(init_start), .init_opts(init_opts),
    .sh_done(sh_done), .sh_load(sh_load), .sh_frame(sh_frame),
    .busy(busy), .done(done)
  );

  spi_pw_shifter #(.CLK_DIV(CLK_DIV), .W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst),
    .load(sh_load), .frame(sh_frame), .frame_done(sh_done),
    .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n)
  );

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R1
  idle_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> spi_cs_n);
endmodule

// File: tb/spi_panel_writer_test.sv
module spi_panel_writer_test;
  localparam int CLK_DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_start = 1'b0;
  logic [7:0] wr_reg = '0;
  logic [15:0] wr_value = '0;
  logic init_start = 1'b0;
  logic [3:0] init_opts = '0;
  logic busy, done, spi_sck, spi_mosi, spi_cs_n;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  spi_panel_writer #(.CLK_DIV(CLK_DIV)) uut (
    .clk(clk), .rst(rst), .wr_start(wr_start), .wr_reg(wr_reg),
    .wr_value(wr_value), .init_start(init_start), .init_opts(init_opts),
    .busy(busy), .done(done), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n)
  );

  always #5 clk = ~clk;

  // Wire monitor: frames, their lengths, clock period and chip-select gap
  logic [23:0] cap = '0;
  int nbits = 0;
  logic [23:0] frames [0:31];
  int nframes = 0;
  int bad_len = 0;
  int bad_period = 0;
  int bad_gap = 0;
  int done_cnt = 0;

  always @(posedge spi_sck) if (spi_cs_n === 1'b0) begin
    cap = {cap[22:0], spi_mosi};
    nbits++;
  end

  always @(posedge spi_cs_n) begin
    if (nbits > 0) begin
      if (nbits != 24) bad_len++;
      if (nframes < 32) frames[nframes] = cap;
      nframes++;
    end
    nbits = 0;
  end

  logic prev_sck = 1'b1;
  logic prev_cs = 1'b1;
  int since_rise = 0;
  bit seen_rise = 0;
  int hi_len = 1000;
  always @(posedge clk) begin
    if (!rst) begin
      since_rise++;
      if (spi_sck && !prev_sck && !spi_cs_n) begin
        if (seen_rise && since_rise != CLK_DIV) bad_period++;
        seen_rise = 1;
        since_rise = 0;
      end
      if (spi_cs_n) seen_rise = 0;
      if (!spi_cs_n && prev_cs && nframes > 0 && hi_len < CLK_DIV) bad_gap++;
      if (spi_cs_n) hi_len++; else hi_len = 0;
      if (done) done_cnt++;
    end
    prev_sck = spi_sck;
    prev_cs = spi_cs_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) begin got = 1; break; end
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [3:0] o);
    exp_word = 16'h00EF | (16'(o[0]) << 8) | (16'(o[1]) << 9) |
               (16'(o[2]) << 11) | (16'(o[3]) << 13);
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk(spi_sck == 1 && spi_cs_n == 1 && busy == 0 && done == 0, "R1",
        "idle outputs", {28'd0, spi_sck, spi_cs_n, busy, done}, 32'hC);
  endtask

  task automatic t_write(input logic [7:0] r, input logic [15:0] v);
    int base;
    bit got;
    base = nframes;
    @(negedge clk);
    wr_reg = r; wr_value = v; wr_start = 1;
    @(negedge clk);
    wr_start = 0;
    chk(busy == 1, "R7", "busy after request", busy, 1);
    wait_done(got);
    chk(got && busy == 0, "R7", "done with busy low", {got, busy}, 2'b10);
    @(negedge clk);
    chk(done == 0, "R7", "done one cycle", done, 0);
    chk(nframes - base == 2, "R5", "two separate frames", nframes - base, 2);
    chk(frames[base] == {8'h74, 8'h00, r}, "R3", "index frame",
        frames[base], {8'h74, 8'h00, r});
    chk(frames[base+1] == {8'h76, v}, "R4", "data frame",
        frames[base+1], {8'h76, v});
  endtask

  task automatic t_ignore_busy;
    int base;
    bit got;
    base = nframes;
    @(negedge clk);
    wr_reg = 8'h3C; wr_value = 16'hA55A; wr_start = 1;
    @(negedge clk);
    wr_start = 0;
    repeat (30) @(negedge clk);
    wr_reg = 8'hFF; wr_value = 16'hFFFF; wr_start = 1; init_start = 1;
    @(negedge clk);
    wr_start = 0; init_start = 0;
    wait_done(got);
    repeat (300) @(negedge clk);
    chk(got && nframes - base == 2, "R8", "frames after busy request",
        nframes - base, 2);
    chk(frames[base] == 24'h74003C && frames[base+1] == 24'h76A55A, "R8",
        "running write content", frames[base+1], 24'h76A55A);
  endtask

  task automatic t_init(input logic [3:0] o, input bit with_write, input string req);
    int base, dbase;
    bit got;
    base = nframes;
    dbase = done_cnt;
    @(negedge clk);
    init_opts = o; init_start = 1;
    if (with_write) begin wr_start = 1; wr_reg = 8'h55; wr_value = 16'h1234; end
    @(negedge clk);
    init_start = 0; wr_start = 0;
    wait_done(got);
    repeat (300) @(negedge clk);
    chk(got && nframes - base == 4, req, "init frame count", nframes - base, 4);
    chk(frames[base] == 24'h740011 && frames[base+1] == 24'h760000, "R9",
        "wake write", frames[base+1], 24'h760000);
    chk(frames[base+2] == 24'h740001, "R9", "outctl index", frames[base+2], 24'h740001);
    chk(frames[base+3] == {8'h76, exp_word(o)}, "R10", "outctl word",
        frames[base+3], {8'h76, exp_word(o)});
    chk(done_cnt - dbase == 1, "R9", "single done", done_cnt - dbase, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_write(8'h11, 16'h0000);
    t_write(8'hA7, 16'hC3F0);
    t_write(8'h01, 16'h8001);
    t_ignore_busy();
    t_init(4'b1111, 0, "R9");
    t_init(4'b0101, 0, "R9");
    t_init(4'b1010, 1, "R11");
    t_reset();
    chk(bad_len == 0, "R2", "24-bit frames", bad_len, 0);
    chk(bad_period == 0, "R6", "sck period", bad_period, 0);
    chk(bad_gap == 0, "R5", "cs high gap", bad_gap, 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule